// File: doc/BRIEF.md
# Watchdog Timer with Match-Triggered Reset Pulse

This block is a watchdog peripheral reached through a plain register read/write port. A 32-bit up-counter advances once per clock while software keeps it enabled. Software refreshes the watchdog by clearing the counter and programs a compare value. When the count reaches that value the block can raise an interrupt flag, freeze the counter, change a match output pin, and start a reset pulse on an internal reset line, an external reset line or both. The pulse length is programmable. A sticky cause bit records that the watchdog fired. That bit survives the ordinary reset the pulse provokes and is cleared only by power-on reset.

The counter's behaviour in each cycle is a mode chosen from the control bits: OFF (enable clear, value kept), CLEAR (forced to zero), HALT (enable set, debug hold selected and the debug-halt input high, value kept) and RUN (increment). The reset pulse comes from a two-state machine. PS_IDLE moves to PS_DRIVE on a match when either reset line is selected, and it loads a down-counter with the programmed length plus five. PS_DRIVE stays while that down-counter is non-zero and returns to PS_IDLE the cycle after it reaches zero. A match that arrives while the machine is in PS_DRIVE is ignored.

Top module: `wdog_timer`

## Requirements
- R1: After reset every register reads 0, and irq, int_rst, ext_rst and match_out are low. The register word index is bus_addr[4:2], with this map: 0x00 flags, 0x04 control, 0x08 count, 0x0C match control, 0x10 compare, 0x14 pin control, 0x18 pulse length, 0x1C cause.
- R2: While control bit 0 is 1, the count rises by one on every clock. Writing 0 to the control register stops counting from the next clock and keeps the value.
- R3: While control bit 1 is 1, the count is held at 0. The count reads 0 one cycle after the write that sets this bit takes effect.
- R4: When control bit 2 is 1 and dbg_halt is high, the count holds. When control bit 2 is 0, dbg_halt has no effect.
- R5: A match is the count equal to the compare value while control bit 0 is 1. Flag bit 0 is set on the clock that follows the first cycle of equality only. irq equals flag bit 0 AND match-control bit 0.
- R6: Writing 1 to flag bit 0 clears it. Writing 0 leaves it unchanged. A match in the same cycle takes precedence over the clear.
- R7: When match-control bit 2 is set, a match freezes the count at the compare value and clears control bit 0.
- R8: Match-control bit 3 routes the pulse to int_rst and bit 4 routes it to ext_rst. The pulse starts one clock after the match and lasts (pulse length + 6) clocks. The pulse length register is 16 bits wide and its upper bits read 0.
- R9: Match-control bit 5 drives int_rst high and bit 6 drives ext_rst high, for as long as each bit is set.
- R10: Pin-control bits [5:4] select the action taken on match: 0 leaves the pin, 1 drives it low, 2 drives it high, 3 toggles it. Bit 0 holds the pin level, is writable, and drives match_out.
- R11: Cause bit 0 is set when a reset pulse starts. It ignores writes, survives rst_n, and is cleared only by por_n.
- R12: Each register reads back at its own offset. Compare is a full 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low system reset; the cause bit is kept |
| por_n | input | 1 | Active-low power-on reset; clears everything |
| dbg_halt | input | 1 | Debug halt request |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 5 | Byte offset; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | 1 | Match interrupt |
| int_rst | output | 1 | Internal reset request pulse |
| ext_rst | output | 1 | External reset output pulse |
| match_out | output | 1 | Match pin level |

## Verification
A control write enabling the counter is taken at one clock edge, and the count first changes on the following edge. A compare of M therefore sets the flag, irq and the pulse start at the clock M+1 edges after that write, and the pulse then holds for exactly length+6 clocks. The bench samples on falling edges and counts edges from the enabling write, so each expected value is pinned to a known cycle. Register reads are combinational and are taken in the same low phase, so they show the state after the last edge. The sweep runs over compare values 1 to 6, pulse lengths 0 to 2 and both reset lines.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W  = 32;
    localparam int ADDR_W = 5;
    localparam int NREG   = 8;

    typedef enum logic [2:0] {
        RI_FLAG  = 3'd0,
        RI_CTRL  = 3'd1,
        RI_COUNT = 3'd2,
        RI_MCTRL = 3'd3,
        RI_CMP   = 3'd4,
        RI_PIN   = 3'd5,
        RI_PLEN  = 3'd6,
        RI_CAUSE = 3'd7
    } reg_idx_e;

    typedef enum logic [1:0] {
        CM_OFF,
        CM_CLEAR,
        CM_HALT,
        CM_RUN
    } cnt_mode_e;

    typedef enum logic [0:0] {
        PS_IDLE,
        PS_DRIVE
    } pulse_state_e;

    typedef enum logic [1:0] {
        PA_KEEP   = 2'd0,
        PA_LOW    = 2'd1,
        PA_HIGH   = 2'd2,
        PA_TOGGLE = 2'd3
    } pin_act_e;
endpackage

// File: rtl/wdog_count.sv
module wdog_count
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic             dbg_en,
    input  logic             dbg_halt,
    input  logic             stop_en,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             hit
);
    cnt_mode_e mode;
    logic      eq, eq_q;

    always_comb begin
        if (clr)                      mode = CM_CLEAR;
        else if (!run)                mode = CM_OFF;
        else if (dbg_en && dbg_halt)  mode = CM_HALT;
        else                          mode = CM_RUN;
    end

    assign eq  = run && (cnt == cmp_val);
    assign hit = eq && !eq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eq_q <= 1'b0;
        end else begin
            eq_q <= eq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (mode)
                CM_CLEAR: cnt <= '0;
                CM_OFF:   cnt <= cnt;
                CM_HALT:  cnt <= cnt;
                CM_RUN:   if (!(hit && stop_en)) cnt <= cnt + 1'b1;
            endcase
        end
    end

    // R3: a held clear yields zero on the next edge
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));

    // R4: debug hold freezes the count
    p_dbg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && run && dbg_en && dbg_halt) |=> $stable(cnt));

    // R2: stopped counter keeps its value
    p_off_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !run) |=> $stable(cnt));

    // R5: equality seen twice in a row is not a new match
    p_first_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (eq && eq_q) |-> !hit);
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int PLEN_W = 16,
    parameter int EXTRA  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              sel_int,
    input  logic              sel_ext,
    input  logic [PLEN_W-1:0] plen,
    output logic              int_on,
    output logic              ext_on,
    output logic              start
);
    localparam int REM_W = PLEN_W + 4;

    pulse_state_e state_q, state_d;
    logic [REM_W-1:0] rem_q;
    logic             use_int_q, use_ext_q;
    logic             trig;

    assign trig = hit && (sel_int || sel_ext);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (trig) state_d = PS_DRIVE;
            PS_DRIVE: if (rem_q == '0) state_d = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= PS_IDLE;
            rem_q     <= '0;
            use_int_q <= 1'b0;
            use_ext_q <= 1'b0;
        end else begin
            state_q <= state_d;
            unique case (state_q)
                PS_IDLE: begin
                    if (trig) begin
                        rem_q     <= REM_W'(plen) + REM_W'(EXTRA - 1);
                        use_int_q <= sel_int;
                        use_ext_q <= sel_ext;
                    end
                end
                PS_DRIVE: begin
                    if (rem_q != '0) rem_q <= rem_q - 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        int_on = 1'b0;
        ext_on = 1'b0;
        start  = 1'b0;
        unique case (state_q)
            PS_IDLE:  start = trig;
            PS_DRIVE: begin
                int_on = use_int_q;
                ext_on = use_ext_q;
            end
        endcase
    end

    // R8: pulse stays up until the length count runs out
    p_pulse_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRIVE && rem_q != '0) |=> (state_q == PS_DRIVE));

    // R8: pulse ends the cycle after the length count is exhausted
    p_pulse_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRIVE && rem_q == '0) |=> (state_q == PS_IDLE));

    // R8: a match during a pulse does not reroute it
    p_no_retrig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRIVE && rem_q != '0) |=> ($stable(use_int_q) && $stable(use_ext_q)));
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PLEN_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              hit,
    input  logic              cause_bit,
    output logic              run,
    output logic              clr,
    output logic              dbg_en,
    output logic              stop_en,
    output logic              sel_int,
    output logic              sel_ext,
    output logic              force_int,
    output logic              force_ext,
    output logic [CNT_W-1:0]  cmp_val,
    output logic [PLEN_W-1:0] plen,
    output logic              irq,
    output logic              match_pin
);
    localparam int MC_W = 7;

    reg_idx_e          idx;
    logic [NREG-1:0]   wr_sel;
    logic              flag_q;
    logic [MC_W-1:0]   mctrl_q;
    pin_act_e          act_q;
    logic              pin_q;

    assign idx = reg_idx_e'(bus_addr[4:2]);

    for (genvar i = 0; i < NREG; i++) begin : g_wsel
        assign wr_sel[i] = bus_en && bus_we && (bus_addr[4:2] == 3'(i));
    end

    assign stop_en   = mctrl_q[2];
    assign sel_int   = mctrl_q[3];
    assign sel_ext   = mctrl_q[4];
    assign force_int = mctrl_q[5];
    assign force_ext = mctrl_q[6];
    assign irq       = flag_q && mctrl_q[0];
    assign match_pin = pin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run    <= 1'b0;
            clr    <= 1'b0;
            dbg_en <= 1'b0;
        end else if (wr_sel[RI_CTRL]) begin
            run    <= bus_wdata[0];
            clr    <= bus_wdata[1];
            dbg_en <= bus_wdata[2];
        end else if (hit && stop_en) begin
            run <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (wr_sel[RI_FLAG] && bus_wdata[0]) begin
            flag_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mctrl_q <= '0;
            cmp_val <= '0;
            plen    <= '0;
        end else begin
            if (wr_sel[RI_MCTRL]) mctrl_q <= bus_wdata[MC_W-1:0];
            if (wr_sel[RI_CMP])   cmp_val <= bus_wdata[CNT_W-1:0];
            if (wr_sel[RI_PLEN])  plen    <= bus_wdata[PLEN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= PA_KEEP;
            pin_q <= 1'b0;
        end else if (wr_sel[RI_PIN]) begin
            act_q <= pin_act_e'(bus_wdata[5:4]);
            pin_q <= bus_wdata[0];
        end else if (hit) begin
            unique case (act_q)
                PA_KEEP:   pin_q <= pin_q;
                PA_LOW:    pin_q <= 1'b0;
                PA_HIGH:   pin_q <= 1'b1;
                PA_TOGGLE: pin_q <= !pin_q;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            RI_FLAG:  bus_rdata[0] = flag_q;
            RI_CTRL:  bus_rdata[2:0] = {dbg_en, clr, run};
            RI_COUNT: bus_rdata[CNT_W-1:0] = cnt_val;
            RI_MCTRL: bus_rdata[MC_W-1:0] = mctrl_q;
            RI_CMP:   bus_rdata[CNT_W-1:0] = cmp_val;
            RI_PIN:   bus_rdata[5:0] = {act_q, 3'b000, pin_q};
            RI_PLEN:  bus_rdata[PLEN_W-1:0] = plen;
            RI_CAUSE: bus_rdata[0] = cause_bit;
        endcase
    end

    logic unused_bus;
    assign unused_bus = ^{bus_addr[1:0], bus_wdata};

    // R5: a match always leaves the flag set
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag_q);

    // R6: write-one clears the flag when no match collides
    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel[RI_FLAG] && bus_wdata[0] && !hit) |=> !flag_q);

    // R7: stop-on-match drops the enable
    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && stop_en && !wr_sel[RI_CTRL]) |=> !run);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PLEN_W = 16,
    parameter int EXTRA  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              dbg_halt,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              int_rst,
    output logic              ext_rst,
    output logic              match_out
);
    logic              sys_rst_n;
    logic              run, clr, dbg_en, stop_en;
    logic              sel_int, sel_ext, force_int, force_ext;
    logic [CNT_W-1:0]  cmp_val, cnt;
    logic [PLEN_W-1:0] plen;
    logic              hit, int_on, ext_on, pulse_start;
    logic              cause_q;

    assign sys_rst_n = rst_n && por_n;

    wdog_regs #(.CNT_W(CNT_W), .PLEN_W(PLEN_W)) u_regs (
        .clk(clk), .rst_n(sys_rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cnt_val(cnt), .hit(hit), .cause_bit(cause_q),
        .run(run), .clr(clr), .dbg_en(dbg_en), .stop_en(stop_en),
        .sel_int(sel_int), .sel_ext(sel_ext),
        .force_int(force_int), .force_ext(force_ext),
        .cmp_val(cmp_val), .plen(plen), .irq(irq), .match_pin(match_out)
    );

    wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(sys_rst_n),
        .run(run), .clr(clr), .dbg_en(dbg_en), .dbg_halt(dbg_halt),
        .stop_en(stop_en), .cmp_val(cmp_val), .cnt(cnt), .hit(hit)
    );

    wdog_pulse #(.PLEN_W(PLEN_W), .EXTRA(EXTRA)) u_pulse (
        .clk(clk), .rst_n(sys_rst_n), .hit(hit),
        .sel_int(sel_int), .sel_ext(sel_ext), .plen(plen),
        .int_on(int_on), .ext_on(ext_on), .start(pulse_start)
    );

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cause_q <= 1'b0;
        end else if (pulse_start) begin
            cause_q <= 1'b1;
        end
    end

    assign int_rst = int_on || force_int;
    assign ext_rst = ext_on || force_ext;

    // R11: cause bit only ever changes by a pulse start
    p_cause_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
        !pulse_start |=> $stable(cause_q));

    // R11: every pulse leaves the cause bit set
    p_cause_on_pulse_r11: assert property (@(posedge clk) disable iff (!sys_rst_n)
        pulse_start |=> cause_q);
endmodule

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
    localparam logic [4:0] A_FLAG = 5'h00, A_CTRL = 5'h04, A_CNT = 5'h08,
                           A_MCTRL = 5'h0C, A_CMP = 5'h10, A_PIN = 5'h14,
                           A_PLEN = 5'h18, A_CAUSE = 5'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0, por_n = 1'b0, dbg_halt = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, int_rst, ext_rst, match_out;
    int          total = 0, bad = 0;
    bit          done = 1'b0;

    always #4 clk = !clk;

    wdog_timer i_wdog_timer (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .dbg_halt(dbg_halt),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .int_rst(int_rst), .ext_rst(ext_rst), .match_out(match_out)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog run did not finish actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            rd(5'(i * 4), v);
            chk("R1", $sformatf("reg%0d after reset", i), v, 0);
        end
        chk("R1", "outputs after reset", {28'd0, irq, int_rst, ext_rst, match_out}, 0);

        // R2: counting and stop with retain
        wr(A_CTRL, 32'h2);
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R2", "count after 10", v, 10);
        wr(A_CTRL, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2", "count kept when stopped", v, 11);
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R2", "count resumed", v, 14);

        // R3: clear while running
        wr(A_CTRL, 32'h3);
        @(negedge clk);
        rd(A_CNT, v); chk("R3", "zero one cycle after clear", v, 0);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R3", "zero held under clear", v, 0);
        wr(A_CTRL, 32'h1);
        repeat (4) @(negedge clk);
        rd(A_CNT, v); chk("R3", "count restarts from zero", v, 4);

        // R4: debug hold
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'h5);
        repeat (6) @(negedge clk);
        rd(A_CNT, v); chk("R4", "held under debug halt", v, 5);
        dbg_halt = 1'b0;
        repeat (2) @(negedge clk);
        rd(A_CNT, v); chk("R4", "resumed after halt", v, 7);
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); chk("R4", "halt ignored without hold bit", v, 10);
        dbg_halt = 1'b0;

        // R5 R7 R8: sweep compare, pulse length and reset line
        for (int m = 1; m <= 6; m++) begin
            for (int p = 0; p <= 2; p++) begin
                for (int s = 0; s <= 1; s++) begin
                    int rise, irq_rise, width;
                    bit other;
                    rise = -1; irq_rise = -1; width = 0; other = 1'b0;
                    wr(A_CTRL, 32'h2);
                    wr(A_FLAG, 32'h1);
                    wr(A_CMP, 32'(m));
                    wr(A_PLEN, 32'(p));
                    wr(A_MCTRL, 32'h5 | (s != 0 ? 32'h8 : 32'h10));
                    wr(A_CTRL, 32'h1);
                    for (int n = 1; n <= m + p + 20; n++) begin
                        logic tgt, oth;
                        @(negedge clk);
                        tgt = (s != 0) ? int_rst : ext_rst;
                        oth = (s != 0) ? ext_rst : int_rst;
                        if (tgt && rise < 0) rise = n;
                        if (tgt) width++;
                        if (oth) other = 1'b1;
                        if (irq && irq_rise < 0) irq_rise = n;
                    end
                    chk("R5", $sformatf("irq cycle m=%0d p=%0d s=%0d", m, p, s), 32'(irq_rise), 32'(m + 1));
                    chk("R8", $sformatf("pulse start m=%0d p=%0d s=%0d", m, p, s), 32'(rise), 32'(m + 1));
                    chk("R8", $sformatf("pulse width m=%0d p=%0d s=%0d", m, p, s), 32'(width), 32'(p + 6));
                    chk("R8", $sformatf("other line quiet m=%0d p=%0d s=%0d", m, p, s), 32'(other), 0);
                    rd(A_CNT, v);
                    chk("R7", $sformatf("frozen at compare m=%0d", m), v, 32'(m));
                    rd(A_CTRL, v);
                    chk("R7", $sformatf("enable dropped m=%0d", m), v, 0);
                end
            end
        end

        // R6: write-one-to-clear
        rd(A_FLAG, v); chk("R6", "flag set before clear", v, 1);
        wr(A_FLAG, 32'h0);
        rd(A_FLAG, v); chk("R6", "write 0 keeps flag", v, 1);
        wr(A_FLAG, 32'h1);
        rd(A_FLAG, v); chk("R6", "write 1 clears flag", v, 0);

        // R5: flag only on first cycle of equality
        wr(A_CTRL, 32'h2);
        wr(A_CMP, 32'd3);
        wr(A_FLAG, 32'h1);
        wr(A_MCTRL, 32'h1);
        wr(A_CTRL, 32'h5);
        repeat (3) @(negedge clk);
        dbg_halt = 1'b1;
        repeat (3) @(negedge clk);
        rd(A_FLAG, v); chk("R5", "flag on equality", v, 1);
        wr(A_FLAG, 32'h1);
        repeat (3) @(negedge clk);
        rd(A_FLAG, v); chk("R5", "no second flag on held equality", v, 0);
        rd(A_CNT, v); chk("R5", "count held at compare", v, 3);
        dbg_halt = 1'b0;

        // R5: interrupt gating
        wr(A_CTRL, 32'h2);
        wr(A_FLAG, 32'h1);
        wr(A_MCTRL, 32'h0);
        wr(A_CTRL, 32'h1);
        repeat (6) @(negedge clk);
        rd(A_FLAG, v); chk("R5", "flag without irq enable", v, 1);
        chk("R5", "irq masked", 32'(irq), 0);

        // R10: pin actions
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 2; b++) begin
                int e;
                e = (a == 0) ? b : (a == 1) ? 0 : (a == 2) ? 1 : 1 - b;
                wr(A_CTRL, 32'h2);
                wr(A_CMP, 32'd2);
                wr(A_MCTRL, 32'h4);
                wr(A_PIN, 32'((a << 4) | b));
                chk("R10", $sformatf("pin before match a=%0d b=%0d", a, b), 32'(match_out), 32'(b));
                wr(A_CTRL, 32'h1);
                repeat (5) @(negedge clk);
                chk("R10", $sformatf("pin after match a=%0d b=%0d", a, b), 32'(match_out), 32'(e));
                rd(A_PIN, v);
                chk("R10", $sformatf("pin readback a=%0d b=%0d", a, b), v, 32'((a << 4) | e));
            end
        end

        // R9: forced reset lines
        wr(A_MCTRL, 32'h20);
        chk("R9", "force internal", {30'd0, int_rst, ext_rst}, 2);
        wr(A_MCTRL, 32'h40);
        chk("R9", "force external", {30'd0, int_rst, ext_rst}, 1);
        wr(A_MCTRL, 32'h0);
        chk("R9", "force released", {30'd0, int_rst, ext_rst}, 0);

        // R12: offsets and widths
        wr(A_CMP, 32'hA5A5_1234);
        wr(A_PLEN, 32'h1234_BEEF);
        rd(A_CMP, v); chk("R12", "compare readback", v, 32'hA5A5_1234);
        rd(A_PLEN, v); chk("R8", "pulse length 16 bits", v, 32'h0000_BEEF);

        // R11: sticky cause
        rd(A_CAUSE, v); chk("R11", "cause set by pulses", v, 1);
        wr(A_CAUSE, 32'h0);
        rd(A_CAUSE, v); chk("R11", "cause ignores write", v, 1);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(A_CMP, v); chk("R11", "system reset clears compare", v, 0);
        rd(A_CAUSE, v); chk("R11", "cause survives system reset", v, 1);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        rd(A_CAUSE, v); chk("R11", "power-on clears cause", v, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule